// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts a 32-bit operand in one of four ways and produces the shifted word together with the shifter carry that a processor's status carry flag takes. The four kinds are logical left, logical right, arithmetic right and rotate right. The amount comes from one of two places. It can be a 5-bit immediate field. It can also be the low byte of a register value, so register-supplied amounts reach 255 and are not folded modulo 32, except when rotating.

The carry rules depend on the kind and on whether the amount is zero, below the word width, equal to it or above it. An amount of zero leaves the operand untouched and passes the incoming carry through. A register-specified shift whose amount register index is the program counter is flagged on a separate illegal-operation output. The outputs are registered, so results appear one clock after the inputs are presented.

Top module: `shft_barrel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `carry_out` and `illegal` are all cleared to zero after that edge.
- R2: Outputs are registered: inputs present at a rising edge appear on the outputs after that edge, and the outputs hold their previous values until then.
- R3: With `amt_from_reg` = 0 the amount is `imm_amt` (0 to 31). With `amt_from_reg` = 1 the amount is `amt_reg_val[7:0]` (0 to 255), and bits [31:8] of `amt_reg_val` have no effect.
- R4: `illegal` is 1 exactly when `amt_from_reg` = 1 and `amt_reg_idx` = 15. Otherwise it is 0.
- R5: For every kind, an amount of 0 gives `result` = `operand` and `carry_out` = `carry_in`.
- R6: Kind 0 (logical left) by n, 1 ≤ n ≤ 31: the result is operand << n and the carry is operand bit 32−n.
- R7: Kind 0 by 32 gives result 0 and carry = operand bit 0. Kind 0 by more than 32 gives result 0 and carry 0.
- R8: Kind 1 (logical right) by n, 1 ≤ n ≤ 31: the result is operand >> n with zero fill and the carry is operand bit n−1. By 32 the result is 0 and the carry is operand bit 31. Above 32 the result is 0 and the carry is 0.
- R9: Kind 2 (arithmetic right) by n, 1 ≤ n ≤ 31: the vacated bits fill with operand bit 31 and the carry is operand bit n−1. By 32 or more, every result bit and the carry equal operand bit 31.
- R10: Kind 3 (rotate right) by a nonzero amount: the result is the operand rotated right by the amount modulo 32, and the carry equals bit 31 of that result. This includes nonzero multiples of 32, where the result equals the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 32 | Value to be shifted |
| kind | input | 2 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg | input | 1 | 1 selects the register-supplied amount, 0 selects the immediate |
| imm_amt | input | 5 | Immediate shift amount |
| amt_reg_idx | input | 4 | Index of the register that supplies the amount |
| amt_reg_val | input | 32 | Value of that register; only bits [7:0] are used |
| carry_in | input | 1 | Current carry flag, passed through on a zero shift |
| result | output | 32 | Registered shifted value |
| carry_out | output | 1 | Registered shifter carry |
| illegal | output | 1 | Registered flag for a program-counter amount register |

## Verification
Each kind is tried with amounts taken from four bands: zero, the interior 1 to 31, exactly 32, and above 32 up to 255. These bands separate the carry rules, which differ at every band edge. The operands have distinct low, high and sign bits, so a carry taken from the wrong bit position or a wrong fill value shows up. Some register amounts have junk in bits above 7, and rotations use multiples of 32, which separates a truncated or modulo-reduced amount from the full byte. The illegal flag is driven with the program-counter index under both amount sources, and the latency is checked by sampling before and after the capturing edge.

// File: rtl/shft_pkg.sv
package shft_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shft_amt_sel.sv
module shft_amt_sel #(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_W     = 5,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 amt_from_reg,
  input  logic [IMM_W-1:0]     imm_amt,
  input  logic [REG_IDX_W-1:0] amt_reg_idx,
  input  logic [DATA_W-1:0]    amt_reg_val,
  output logic [AMT_W-1:0]     eff_amt,
  output logic                 illegal
);
  localparam int PAD_W = AMT_W - IMM_W;
  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  always_comb begin
    if (amt_from_reg) eff_amt = amt_reg_val[AMT_W-1:0];
    else              eff_amt = {{PAD_W{1'b0}}, imm_amt};
  end

  assign illegal = amt_from_reg && (amt_reg_idx == PC_CODE);
endmodule

// File: rtl/shft_core.sv
module shft_core
  import shft_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int ROT_W = $clog2(DATA_W);

  logic [DATA_W:0]          lsl_ext;
  logic [DATA_W:0]          lsr_ext;
  logic signed [DATA_W:0]   asr_in;
  logic signed [DATA_W:0]   asr_ext;
  logic [2*DATA_W-1:0]      ror_ext;
  logic [DATA_W-1:0]        ror_res;

  // Left: an extra bit above the word catches the last bit shifted out.
  assign lsl_ext = {1'b0, operand} << amt;
  // Right: an extra bit below the word catches the last bit shifted out.
  assign lsr_ext = {operand, 1'b0} >> amt;
  assign asr_in  = {operand, 1'b0};
  assign asr_ext = asr_in >>> amt;
  assign ror_ext = {operand, operand} >> amt[ROT_W-1:0];
  assign ror_res = ror_ext[DATA_W-1:0];

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          result    = lsl_ext[DATA_W-1:0];
          carry_out = lsl_ext[DATA_W];
        end
        SK_LSR: begin
          result    = lsr_ext[DATA_W:1];
          carry_out = lsr_ext[0];
        end
        SK_ASR: begin
          result    = asr_ext[DATA_W:1];
          carry_out = asr_ext[0];
        end
        default: begin
          result    = ror_res;
          carry_out = ror_res[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shft_barrel.sv
module shft_barrel
  import shft_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_W     = 5,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    operand,
  input  logic [1:0]           kind,
  input  logic                 amt_from_reg,
  input  logic [IMM_W-1:0]     imm_amt,
  input  logic [REG_IDX_W-1:0] amt_reg_idx,
  input  logic [DATA_W-1:0]    amt_reg_val,
  input  logic                 carry_in,
  output logic [DATA_W-1:0]    result,
  output logic                 carry_out,
  output logic                 illegal
);
  logic [AMT_W-1:0]  eff_amt;
  logic              illegal_c;
  logic [DATA_W-1:0] result_c;
  logic              carry_c;

  shft_amt_sel #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W),
    .REG_IDX_W(REG_IDX_W), .PC_IDX(PC_IDX)
  ) u_amt (
    .amt_from_reg(amt_from_reg),
    .imm_amt     (imm_amt),
    .amt_reg_idx (amt_reg_idx),
    .amt_reg_val (amt_reg_val),
    .eff_amt     (eff_amt),
    .illegal     (illegal_c)
  );

  shft_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .operand  (operand),
    .kind     (shift_kind_e'(kind)),
    .amt      (eff_amt),
    .carry_in (carry_in),
    .result   (result_c),
    .carry_out(carry_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      result    <= result_c;
      carry_out <= carry_c;
      illegal   <= illegal_c;
    end
  end
endmodule

// File: rtl/shft_barrel_chk.sv
module shft_barrel_chk #(
  parameter int DATA_W    = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_W     = 5,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_W-1:0]    operand,
  input logic [1:0]           kind,
  input logic                 amt_from_reg,
  input logic [IMM_W-1:0]     imm_amt,
  input logic [REG_IDX_W-1:0] amt_reg_idx,
  input logic [DATA_W-1:0]    amt_reg_val,
  input logic                 carry_in,
  input logic [DATA_W-1:0]    result,
  input logic                 carry_out,
  input logic                 illegal
);
  logic past_ok;
  logic [AMT_W-1:0] amt_seen;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign amt_seen = amt_from_reg ? amt_reg_val[AMT_W-1:0] : AMT_W'(imm_amt);

  // R4
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> illegal == $past(amt_from_reg && amt_reg_idx == REG_IDX_W'(PC_IDX)));

  // R5
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(amt_seen == '0)) |->
      (result == $past(operand) && carry_out == $past(carry_in)));

  // R7
  lsl_over_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(kind == 2'd0 && amt_seen > AMT_W'(DATA_W))) |->
      (result == '0 && !carry_out));

  // R9
  asr_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(kind == 2'd2 && amt_seen >= AMT_W'(DATA_W))) |->
      (carry_out == $past(operand[DATA_W-1]) &&
       (result == '0 || result == '1)));

  // R10
  ror_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(kind == 2'd3 && amt_seen != '0)) |->
      (carry_out == result[DATA_W-1] &&
       $countones(result) == $countones($past(operand))));
endmodule

bind shft_barrel shft_barrel_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W),
  .REG_IDX_W(REG_IDX_W), .PC_IDX(PC_IDX)
) u_chk (
  .clk(clk), .rst(rst), .operand(operand), .kind(kind),
  .amt_from_reg(amt_from_reg), .imm_amt(imm_amt),
  .amt_reg_idx(amt_reg_idx), .amt_reg_val(amt_reg_val),
  .carry_in(carry_in), .result(result), .carry_out(carry_out),
  .illegal(illegal)
);

// File: tb/shft_barrel_tb.sv
module shft_barrel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [1:0]  kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [3:0]  amt_reg_idx = '0;
  logic [31:0] amt_reg_val = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        illegal;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shft_barrel u_dut (
    .clk(clk), .rst(rst), .operand(operand), .kind(kind),
    .amt_from_reg(amt_from_reg), .imm_amt(imm_amt),
    .amt_reg_idx(amt_reg_idx), .amt_reg_val(amt_reg_val),
    .carry_in(carry_in), .result(result), .carry_out(carry_out),
    .illegal(illegal)
  );

  // Bit-at-a-time model of the shift rules.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [1:0] k,
                                        input int n, input logic cin);
    logic [31:0] v = op;
    logic c = cin;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0];  v = v >> 1; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [31:0] op, input logic [1:0] k,
                         input logic from_reg, input logic [4:0] imm,
                         input logic [3:0] idx, input logic [31:0] rv, input logic cin);
    logic [32:0] e;
    int n;
    @(negedge clk);
    operand = op; kind = k; amt_from_reg = from_reg; imm_amt = imm;
    amt_reg_idx = idx; amt_reg_val = rv; carry_in = cin;
    n = from_reg ? int'(rv[7:0]) : int'(imm);
    e = model(op, k, n, cin);
    @(negedge clk);
    check(tag, "result", result, e[31:0]);
    check(tag, "carry", {31'b0, carry_out}, {31'b0, e[32]});
    check(tag, "illegal", {31'b0, illegal}, {31'b0, from_reg && idx == 4'd15});
  endtask

  task automatic t_reset;
    run_one("R2", 32'h8000_0001, 2'd0, 1'b1, 5'd0, 4'd3, 32'd1, 1'b0);
    @(negedge clk);
    rst = 1'b1; amt_reg_idx = 4'd15;
    @(negedge clk);
    check("R1", "result", result, 32'h0);
    check("R1", "carry", {31'b0, carry_out}, 32'h0);
    check("R1", "illegal", {31'b0, illegal}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    run_one("R2", 32'h0000_00F0, 2'd1, 1'b0, 5'd4, 4'd0, 32'h0, 1'b0);
    @(negedge clk);
    operand = 32'hFFFF_0000; kind = 2'd0; imm_amt = 5'd8;
    #1;
    check("R2", "hold", result, 32'h0000_000F);
    @(negedge clk);
    check("R2", "update", result, 32'hFF00_0000);
  endtask

  task automatic t_lsl;
    run_one("R6", 32'hA5A5_0F0F, 2'd0, 1'b0, 5'd1, 4'd0, 0, 1'b0);
    run_one("R6", 32'h0000_0001, 2'd0, 1'b0, 5'd31, 4'd0, 0, 1'b1);
    run_one("R6", 32'h4000_0000, 2'd0, 1'b1, 5'd0, 4'd2, 32'd2, 1'b0);
    run_one("R7", 32'h0000_0001, 2'd0, 1'b1, 5'd0, 4'd2, 32'd32, 1'b0);
    run_one("R7", 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 4'd2, 32'd33, 1'b1);
    run_one("R7", 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 4'd2, 32'd255, 1'b1);
  endtask

  task automatic t_lsr;
    run_one("R8", 32'h8000_0003, 2'd1, 1'b0, 5'd1, 4'd0, 0, 1'b0);
    run_one("R8", 32'h8000_0000, 2'd1, 1'b0, 5'd31, 4'd0, 0, 1'b0);
    run_one("R8", 32'h8000_0000, 2'd1, 1'b1, 5'd0, 4'd1, 32'd32, 1'b0);
    run_one("R8", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 4'd1, 32'd40, 1'b1);
  endtask

  task automatic t_asr;
    run_one("R9", 32'h8000_0010, 2'd2, 1'b0, 5'd5, 4'd0, 0, 1'b0);
    run_one("R9", 32'h7000_0008, 2'd2, 1'b0, 5'd4, 4'd0, 0, 1'b0);
    run_one("R9", 32'h8000_0000, 2'd2, 1'b1, 5'd0, 4'd4, 32'd32, 1'b0);
    run_one("R9", 32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 4'd4, 32'd200, 1'b1);
  endtask

  task automatic t_ror;
    run_one("R10", 32'h0000_0001, 2'd3, 1'b0, 5'd1, 4'd0, 0, 1'b0);
    run_one("R10", 32'h1234_5678, 2'd3, 1'b0, 5'd12, 4'd0, 0, 1'b0);
    run_one("R10", 32'h8000_0001, 2'd3, 1'b1, 5'd0, 4'd5, 32'd32, 1'b0);
    run_one("R10", 32'h0000_0001, 2'd3, 1'b1, 5'd0, 4'd5, 32'd64, 1'b1);
    run_one("R10", 32'h1234_5678, 2'd3, 1'b1, 5'd0, 4'd5, 32'd44, 1'b0);
  endtask

  task automatic t_zero;
    for (int k = 0; k < 4; k++) begin
      run_one("R5", 32'hDEAD_BEEF, 2'(k), 1'b0, 5'd0, 4'd0, 0, 1'b1);
      run_one("R5", 32'h1357_9BDF, 2'(k), 1'b1, 5'd7, 4'd6, 32'h0000_0000, 1'b0);
    end
  endtask

  task automatic t_source;
    // R3: upper register bits ignored; immediate used when from_reg is 0
    run_one("R3", 32'h8000_0001, 2'd1, 1'b1, 5'd9, 4'd7, 32'hFFFF_FF01, 1'b0);
    run_one("R3", 32'h8000_0001, 2'd0, 1'b1, 5'd9, 4'd7, 32'h1234_0000, 1'b1);
    run_one("R3", 32'h0000_FF00, 2'd1, 1'b0, 5'd8, 4'd7, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_illegal;
    run_one("R4", 32'h0000_0F00, 2'd0, 1'b1, 5'd0, 4'd15, 32'd4, 1'b0);
    run_one("R4", 32'h0000_0F00, 2'd0, 1'b0, 5'd3, 4'd15, 32'd4, 1'b0);
    run_one("R4", 32'h0000_0F00, 2'd0, 1'b1, 5'd0, 4'd14, 32'd4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "result", result, 32'h0);
    check("R1", "illegal", {31'b0, illegal}, 32'h0);
    rst = 1'b0;
    t_latency();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_zero();
    t_source();
    t_illegal();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule